// File: doc/BRIEF.md
# Exception Entry Controller

This block updates the control registers of a 32-bit soft processor core when the core takes an exception or an interrupt. The pipeline raises a single-cycle take strobe with a 5-bit cause code, the program counter of the excepting instruction and, for misaligned accesses, the faulting address. The block holds the control state that the entry sequence touches: processor status, saved status, break-saved status, the exception cause register, the bad-address register, the TLB flag register, and the exception and break return addresses. It also produces a one-cycle redirect carrying the handler address.

The sequence depends on the class of the cause and on whether a handler is already running, meaning the handler-active bit is set in status. A TLB miss outside a handler takes a fast path to its own vector. A miss inside a handler is recorded as a double miss and keeps the earlier saved context. Breaks save into their own pair of registers. Some classes save status and the return address only when no handler is active. Software reaches every register through a simple indexed write port. Each register is visible on its own output.

Top module: `exc_entry_ctrl`

## Requirements
- R1: After reset every held register is zero and the redirect output is low.
- R2: A strobe sampled at clock edge E is applied at edge E+1. From then on the registers show the new values, and the redirect is high with the handler address for exactly one cycle.
- R3: Status bit positions are PIE=0, U=1, EH=2, IH=3. Each applied entry clears PIE and U. A hardware interrupt sets IH. Every other cause sets EH.
- R4: Cause codes are: interrupt 2, trap 3, illegal 5, misaligned 6, break 7, supervisor address 9, supervisor instruction 10, supervisor data 11, TLB miss 12, permission execute 13, permission read 14, permission write 15. For every cause except misaligned, exception register bits 6:2 receive the code and all other bits keep their value.
- R5: An interrupt is taken only when PIE is set. When it is taken, status is copied to saved status, the return address becomes PC+4 and the redirect goes to the general vector. When PIE is clear, no register changes and no redirect occurs.
- R6: A TLB miss with EH clear saves status and PC+4. It clears the double flag (TLB flag bit 1) and sets the write-enable flag (bit 0), then redirects to the fast-miss vector.
- R7: A TLB miss with EH set leaves saved status and return address unchanged. It sets the double flag and redirects to the general vector.
- R8: A permission fault (read, write or execute) always saves status and PC+4 and redirects to the general vector.
- R9: Supervisor-address, supervisor-instruction, supervisor-data, trap and illegal causes save status and PC+4 only when EH was clear. All of them redirect to the general vector.
- R10: A break saves status into break-saved status and PC+4 into the break return address, only when EH was clear. It leaves saved status and the exception return address unchanged.
- R11: A misaligned entry loads the bad-address register with the faulting address and the whole exception register with 6 shifted left by 2. It saves status and the return address under the same rule as R9.
- R12: An unrecognised cause code is handled as an illegal instruction, and code 5 is written to the cause field.
- R13: A strobe that arrives while an earlier entry is being applied is applied one cycle later than normal. Requests are applied in arrival order, and each one sees the status left by the one before it.
- R14: Software writes select a register by index: 0 status, 1 saved status, 2 break-saved status, 3 exception, 4 bad address, 5 TLB flags, 6 exception return, 7 break return. A software write in a cycle where an entry is applied is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| take_i | input | 1 | One-cycle request to take an exception |
| cause_i | input | 5 | Cause code of the request |
| pc_i | input | 32 | Address of the excepting instruction |
| fault_addr_i | input | 32 | Faulting data address for misaligned entries |
| vec_general_i | input | 32 | General exception handler address |
| vec_fast_tlb_i | input | 32 | Fast TLB-miss handler address |
| sw_we_i | input | 1 | Software register write strobe |
| sw_sel_i | input | 3 | Software write register index |
| sw_wdata_i | input | 32 | Software write data |
| redir_valid_o | output | 1 | One-cycle fetch redirect |
| redir_pc_o | output | 32 | Handler address for the redirect |
| status_o | output | 32 | Processor status |
| estatus_o | output | 32 | Saved status |
| bstatus_o | output | 32 | Break-saved status |
| exc_o | output | 32 | Exception cause register |
| badaddr_o | output | 32 | Bad-address register |
| tlbmisc_o | output | 32 | TLB flag register |
| ea_o | output | 32 | Exception return address |
| ba_o | output | 32 | Break return address |

## Verification
Every cause class is driven from several starting status words, with PIE, U, EH and IH set in different combinations. This separates entries that save their context unconditionally from those that save only outside a handler, and shows that IH survives an entry. The TLB miss is tried with EH clear and with EH set, and with the double flag preset both ways, so the fast path and the double path can be told apart by vector and by flags. Back-to-back strobes, including a masked second interrupt, show the deferral and the ordering. A software write that collides with an entry shows which of the two wins.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;
  localparam int XLEN     = 32;
  localparam int CODE_W   = 5;
  localparam int CODE_LSB = 2;
  localparam int SEL_W    = 3;

  // status bit positions
  localparam int ST_PIE = 0;
  localparam int ST_U   = 1;
  localparam int ST_EH  = 2;
  localparam int ST_IH  = 3;

  // TLB flag bit positions
  localparam int TM_WE  = 0;
  localparam int TM_DBL = 1;

  localparam logic [CODE_W-1:0] C_IRQ      = 5'd2;
  localparam logic [CODE_W-1:0] C_TRAP     = 5'd3;
  localparam logic [CODE_W-1:0] C_ILLEGAL  = 5'd5;
  localparam logic [CODE_W-1:0] C_MISALIGN = 5'd6;
  localparam logic [CODE_W-1:0] C_BREAK    = 5'd7;
  localparam logic [CODE_W-1:0] C_SUP_ADDR = 5'd9;
  localparam logic [CODE_W-1:0] C_SUP_INST = 5'd10;
  localparam logic [CODE_W-1:0] C_SUP_DATA = 5'd11;
  localparam logic [CODE_W-1:0] C_TLB_MISS = 5'd12;
  localparam logic [CODE_W-1:0] C_PERM_X   = 5'd13;
  localparam logic [CODE_W-1:0] C_PERM_R   = 5'd14;
  localparam logic [CODE_W-1:0] C_PERM_W   = 5'd15;

  typedef enum logic [2:0] {
    CL_IRQ, CL_TLB_MISS, CL_PERM, CL_COND, CL_BREAK, CL_MISALIGN
  } exc_class_e;

  typedef enum logic [SEL_W-1:0] {
    RI_STATUS, RI_ESTATUS, RI_BSTATUS, RI_EXC,
    RI_BADADDR, RI_TLBMISC, RI_EA, RI_BA
  } reg_idx_e;

  typedef struct packed {
    logic [CODE_W-1:0] code;
    logic [XLEN-1:0]   pc;
    logic [XLEN-1:0]   fault;
  } exc_req_t;

  localparam int REQ_W = $bits(exc_req_t);

  function automatic logic [XLEN-1:0] f_ret_addr(input logic [XLEN-1:0] pc,
                                                 input int step);
    return pc + XLEN'(step);
  endfunction

  // status after entry: handler bit raised, PIE and U dropped
  function automatic logic [XLEN-1:0] f_enter_status(input logic [XLEN-1:0] st,
                                                     input logic is_irq);
    logic [XLEN-1:0] r;
    r = st;
    if (is_irq) r[ST_IH] = 1'b1;
    else        r[ST_EH] = 1'b1;
    r[ST_PIE] = 1'b0;
    r[ST_U]   = 1'b0;
    return r;
  endfunction

  // replace only the cause field
  function automatic logic [XLEN-1:0] f_put_code(input logic [XLEN-1:0] exc,
                                                 input logic [CODE_W-1:0] code);
    logic [XLEN-1:0] r;
    r = exc;
    r[CODE_LSB +: CODE_W] = code;
    return r;
  endfunction

  // whole register holding only the cause field
  function automatic logic [XLEN-1:0] f_only_code(input logic [CODE_W-1:0] code);
    logic [XLEN-1:0] r;
    r = '0;
    r[CODE_LSB +: CODE_W] = code;
    return r;
  endfunction
endpackage

// File: rtl/exc_req_queue.sv
module exc_req_queue #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push_i,
  input  logic [W-1:0] din_i,
  output logic         slot_valid_o,
  output logic [W-1:0] slot_data_o
);
  logic         slot_v, hold_v;
  logic [W-1:0] slot_d, hold_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_v <= 1'b0;
      slot_d <= '0;
      hold_v <= 1'b0;
      hold_d <= '0;
    end else begin
      if (hold_v) begin
        slot_v <= 1'b1;
        slot_d <= hold_d;
      end else if (push_i && !slot_v) begin
        slot_v <= 1'b1;
        slot_d <= din_i;
      end else begin
        slot_v <= 1'b0;
      end
      if (push_i && (slot_v || hold_v)) begin
        hold_v <= 1'b1;
        hold_d <= din_i;
      end else begin
        hold_v <= 1'b0;
      end
    end
  end

  assign slot_valid_o = slot_v;
  assign slot_data_o  = slot_d;
endmodule

// File: rtl/exc_class_decode.sv
module exc_class_decode
  import exc_entry_pkg::*;
(
  input  logic [CODE_W-1:0] code_i,
  output exc_class_e        cls_o,
  output logic [CODE_W-1:0] code_o
);
  always_comb begin
    code_o = code_i;
    unique case (code_i)
      C_IRQ:                            cls_o = CL_IRQ;
      C_TLB_MISS:                       cls_o = CL_TLB_MISS;
      C_PERM_X, C_PERM_R, C_PERM_W:     cls_o = CL_PERM;
      C_TRAP, C_ILLEGAL,
      C_SUP_ADDR, C_SUP_INST, C_SUP_DATA: cls_o = CL_COND;
      C_BREAK:                          cls_o = CL_BREAK;
      C_MISALIGN:                       cls_o = CL_MISALIGN;
      default: begin
        cls_o  = CL_COND;
        code_o = C_ILLEGAL;
      end
    endcase
  end
endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
  import exc_entry_pkg::*;
#(
  parameter int PC_STEP = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            take_i,
  input  logic [4:0]      cause_i,
  input  logic [31:0]     pc_i,
  input  logic [31:0]     fault_addr_i,
  input  logic [31:0]     vec_general_i,
  input  logic [31:0]     vec_fast_tlb_i,
  input  logic            sw_we_i,
  input  logic [2:0]      sw_sel_i,
  input  logic [31:0]     sw_wdata_i,
  output logic            redir_valid_o,
  output logic [31:0]     redir_pc_o,
  output logic [31:0]     status_o,
  output logic [31:0]     estatus_o,
  output logic [31:0]     bstatus_o,
  output logic [31:0]     exc_o,
  output logic [31:0]     badaddr_o,
  output logic [31:0]     tlbmisc_o,
  output logic [31:0]     ea_o,
  output logic [31:0]     ba_o
);
  exc_req_t          in_req, q_req;
  logic              q_valid;
  exc_class_e        q_cls;
  logic [CODE_W-1:0] q_code;

  logic [XLEN-1:0] status_q, estatus_q, bstatus_q, exc_q;
  logic [XLEN-1:0] badaddr_q, tlbmisc_q, ea_q, ba_q;
  logic            redir_valid_q;
  logic [XLEN-1:0] redir_pc_q;

  // named events, also observed by the checker
  logic eh_now, irq_reject, apply_fire, apply_irq, apply_misalign;
  logic fast_miss, double_miss, save_e, save_b, sw_take;
  logic [XLEN-1:0] ret_addr;

  assign in_req = '{code: cause_i, pc: pc_i, fault: fault_addr_i};

  exc_req_queue #(.W(REQ_W)) u_queue (
    .clk         (clk),
    .rst_n       (rst_n),
    .push_i      (take_i),
    .din_i       (in_req),
    .slot_valid_o(q_valid),
    .slot_data_o (q_req)
  );

  exc_class_decode u_decode (
    .code_i(q_req.code),
    .cls_o (q_cls),
    .code_o(q_code)
  );

  assign eh_now         = status_q[ST_EH];
  assign irq_reject     = q_valid && (q_cls == CL_IRQ) && !status_q[ST_PIE];
  assign apply_fire     = q_valid && !irq_reject;
  assign apply_irq      = apply_fire && (q_cls == CL_IRQ);
  assign apply_misalign = apply_fire && (q_cls == CL_MISALIGN);
  assign fast_miss      = apply_fire && (q_cls == CL_TLB_MISS) && !eh_now;
  assign double_miss    = apply_fire && (q_cls == CL_TLB_MISS) && eh_now;
  assign save_e         = apply_fire &&
                          ((q_cls == CL_IRQ) || (q_cls == CL_PERM) ||
                           ((q_cls == CL_TLB_MISS) && !eh_now) ||
                           (((q_cls == CL_COND) || (q_cls == CL_MISALIGN)) && !eh_now));
  assign save_b         = apply_fire && (q_cls == CL_BREAK) && !eh_now;
  assign sw_take        = sw_we_i && !apply_fire;
  assign ret_addr       = f_ret_addr(q_req.pc, PC_STEP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q      <= '0;
      estatus_q     <= '0;
      bstatus_q     <= '0;
      exc_q         <= '0;
      badaddr_q     <= '0;
      tlbmisc_q     <= '0;
      ea_q          <= '0;
      ba_q          <= '0;
      redir_valid_q <= 1'b0;
      redir_pc_q    <= '0;
    end else begin
      redir_valid_q <= apply_fire;
      if (apply_fire) begin
        redir_pc_q <= fast_miss ? vec_fast_tlb_i : vec_general_i;
        status_q   <= f_enter_status(status_q, apply_irq);
        exc_q      <= apply_misalign ? f_only_code(C_MISALIGN)
                                     : f_put_code(exc_q, q_code);
        if (save_e) begin
          estatus_q <= status_q;
          ea_q      <= ret_addr;
        end
        if (save_b) begin
          bstatus_q <= status_q;
          ba_q      <= ret_addr;
        end
        if (apply_misalign) badaddr_q <= q_req.fault;
        if (fast_miss) begin
          tlbmisc_q[TM_DBL] <= 1'b0;
          tlbmisc_q[TM_WE]  <= 1'b1;
        end
        if (double_miss) tlbmisc_q[TM_DBL] <= 1'b1;
      end else if (sw_take) begin
        unique case (reg_idx_e'(sw_sel_i))
          RI_STATUS:  status_q  <= sw_wdata_i;
          RI_ESTATUS: estatus_q <= sw_wdata_i;
          RI_BSTATUS: bstatus_q <= sw_wdata_i;
          RI_EXC:     exc_q     <= sw_wdata_i;
          RI_BADADDR: badaddr_q <= sw_wdata_i;
          RI_TLBMISC: tlbmisc_q <= sw_wdata_i;
          RI_EA:      ea_q      <= sw_wdata_i;
          RI_BA:      ba_q      <= sw_wdata_i;
          default:    ;
        endcase
      end
    end
  end

  assign redir_valid_o = redir_valid_q;
  assign redir_pc_o    = redir_pc_q;
  assign status_o      = status_q;
  assign estatus_o     = estatus_q;
  assign bstatus_o     = bstatus_q;
  assign exc_o         = exc_q;
  assign badaddr_o     = badaddr_q;
  assign tlbmisc_o     = tlbmisc_q;
  assign ea_o          = ea_q;
  assign ba_o          = ba_q;
endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk
  import exc_entry_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              sw_we,
  input logic              apply_fire,
  input logic              apply_irq,
  input logic              apply_misalign,
  input logic              irq_reject,
  input logic              double_miss,
  input logic [CODE_W-1:0] q_code,
  input logic [XLEN-1:0]   status,
  input logic [XLEN-1:0]   estatus,
  input logic [XLEN-1:0]   exc,
  input logic [XLEN-1:0]   ea,
  input logic [XLEN-1:0]   tlbmisc,
  input logic              redir_valid
);
  AST_ENTRY_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    apply_fire |=> !status[ST_PIE] && !status[ST_U] && (status[ST_EH] || status[ST_IH])); // R3

  AST_IRQ_KEEPS_EH: assert property (@(posedge clk) disable iff (!rst_n)
    apply_irq |=> status[ST_IH] && (status[ST_EH] == $past(status[ST_EH]))); // R3

  AST_CAUSE_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
    (apply_fire && !apply_misalign) |=> (exc[CODE_LSB +: CODE_W] == $past(q_code)) &&
      (exc[XLEN-1:CODE_LSB+CODE_W] == $past(exc[XLEN-1:CODE_LSB+CODE_W])) &&
      (exc[CODE_LSB-1:0] == $past(exc[CODE_LSB-1:0]))); // R4

  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_reject && !sw_we) |=> $stable(status) && !redir_valid); // R5

  AST_DOUBLE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    double_miss |=> $stable(estatus) && $stable(ea) && tlbmisc[TM_DBL]); // R7

  AST_MISALIGN_EXC: assert property (@(posedge clk) disable iff (!rst_n)
    apply_misalign |=> (exc == f_only_code(C_MISALIGN))); // R11

  AST_REDIR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    redir_valid |-> $past(apply_fire)); // R2
endmodule

bind exc_entry_ctrl exc_entry_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .sw_we         (sw_we_i),
  .apply_fire    (apply_fire),
  .apply_irq     (apply_irq),
  .apply_misalign(apply_misalign),
  .irq_reject    (irq_reject),
  .double_miss   (double_miss),
  .q_code        (q_code),
  .status        (status_q),
  .estatus       (estatus_q),
  .exc           (exc_q),
  .ea            (ea_q),
  .tlbmisc       (tlbmisc_q),
  .redir_valid   (redir_valid_q)
);

// File: tb/sim_exc_entry_ctrl.sv
`timescale 1ns/1ps
module sim_exc_entry_ctrl;
  localparam logic [31:0] VGEN  = 32'h0000_0100;
  localparam logic [31:0] VFAST = 32'h0000_0200;
  localparam logic [31:0] PE    = 32'hE5E5_0000;
  localparam logic [31:0] PB    = 32'hB5B5_0000;
  localparam logic [31:0] PX    = 32'h1234_5683;
  localparam logic [31:0] PBAD  = 32'hBAD0_0000;
  localparam logic [31:0] PEA   = 32'hEA00_0000;
  localparam logic [31:0] PBA   = 32'hBA00_0000;

  typedef struct packed {
    logic [3:0] st0;
    logic [4:0] code;
    logic [1:0] tlb_pre;
    logic [3:0] exp_st;
    logic [4:0] exp_code;
    logic       sv_e;
    logic       sv_b;
    logic [1:0] vsel;    // 0 general, 1 fast, 2 none
    logic [1:0] tlb_exp;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t TBL [0:NV-1] = '{
    '{4'h3, 5'd2,  2'b00, 4'h8, 5'd2,  1'b1, 1'b0, 2'd0, 2'b00},
    '{4'h2, 5'd2,  2'b00, 4'h2, 5'd2,  1'b0, 1'b0, 2'd2, 2'b00},
    '{4'h3, 5'd12, 2'b10, 4'h4, 5'd12, 1'b1, 1'b0, 2'd1, 2'b01},
    '{4'h4, 5'd12, 2'b00, 4'h4, 5'd12, 1'b0, 1'b0, 2'd0, 2'b10},
    '{4'h4, 5'd14, 2'b00, 4'h4, 5'd14, 1'b1, 1'b0, 2'd0, 2'b00},
    '{4'h3, 5'd15, 2'b01, 4'h4, 5'd15, 1'b1, 1'b0, 2'd0, 2'b01},
    '{4'h9, 5'd13, 2'b00, 4'hC, 5'd13, 1'b1, 1'b0, 2'd0, 2'b00},
    '{4'h3, 5'd3,  2'b00, 4'h4, 5'd3,  1'b1, 1'b0, 2'd0, 2'b00},
    '{4'h6, 5'd3,  2'b00, 4'h4, 5'd3,  1'b0, 1'b0, 2'd0, 2'b00},
    '{4'h1, 5'd5,  2'b00, 4'h4, 5'd5,  1'b1, 1'b0, 2'd0, 2'b00},
    '{4'h4, 5'd9,  2'b00, 4'h4, 5'd9,  1'b0, 1'b0, 2'd0, 2'b00},
    '{4'h2, 5'd10, 2'b00, 4'h4, 5'd10, 1'b1, 1'b0, 2'd0, 2'b00},
    '{4'h7, 5'd11, 2'b00, 4'h4, 5'd11, 1'b0, 1'b0, 2'd0, 2'b00},
    '{4'h3, 5'd7,  2'b00, 4'h4, 5'd7,  1'b0, 1'b1, 2'd0, 2'b00},
    '{4'h5, 5'd7,  2'b00, 4'h4, 5'd7,  1'b0, 1'b0, 2'd0, 2'b00},
    '{4'h1, 5'd20, 2'b00, 4'h4, 5'd5,  1'b1, 1'b0, 2'd0, 2'b00}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic take = 1'b0;
  logic [4:0] cause = '0;
  logic [31:0] pc = '0, fault = '0;
  logic sw_we = 1'b0;
  logic [2:0] sw_sel = '0;
  logic [31:0] sw_wdata = '0;
  logic redir_valid;
  logic [31:0] redir_pc, status, estatus, bstatus, exc, badaddr, tlbmisc, ea, ba;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  exc_entry_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .take_i(take), .cause_i(cause), .pc_i(pc),
    .fault_addr_i(fault), .vec_general_i(VGEN), .vec_fast_tlb_i(VFAST),
    .sw_we_i(sw_we), .sw_sel_i(sw_sel), .sw_wdata_i(sw_wdata),
    .redir_valid_o(redir_valid), .redir_pc_o(redir_pc), .status_o(status),
    .estatus_o(estatus), .bstatus_o(bstatus), .exc_o(exc), .badaddr_o(badaddr),
    .tlbmisc_o(tlbmisc), .ea_o(ea), .ba_o(ba)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
    end
  endtask

  task automatic sw_write(input logic [2:0] sel, input logic [31:0] d);
    @(negedge clk);
    sw_we = 1'b1; sw_sel = sel; sw_wdata = d;
    @(negedge clk);
    sw_we = 1'b0;
  endtask

  task automatic preset(input logic [3:0] st0, input logic [1:0] tlb0);
    sw_write(3'd0, {28'h0, st0});
    sw_write(3'd1, PE);
    sw_write(3'd2, PB);
    sw_write(3'd3, PX);
    sw_write(3'd4, PBAD);
    sw_write(3'd5, {30'h0, tlb0});
    sw_write(3'd6, PEA);
    sw_write(3'd7, PBA);
  endtask

  task automatic strobe(input logic [4:0] c, input logic [31:0] p, input logic [31:0] f);
    @(negedge clk);
    take = 1'b1; cause = c; pc = p; fault = f;
    @(negedge clk);
    take = 1'b0;
  endtask

  function automatic string tag_of(input logic [4:0] c, input logic [3:0] st0);
    case (c)
      5'd2:  return "R5";
      5'd12: return st0[2] ? "R7" : "R6";
      5'd13, 5'd14, 5'd15: return "R8";
      5'd7:  return "R10";
      5'd3, 5'd5, 5'd9, 5'd10, 5'd11: return "R9";
      default: return "R12";
    endcase
  endfunction

  function automatic logic [31:0] put5(input logic [31:0] r, input logic [4:0] c);
    return (r & ~32'h0000_007C) | {25'h0, c, 2'b00};
  endfunction

  initial begin
    #(5ns * 150000);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "redir", {31'h0, redir_valid}, 32'h0);
    chk("R1", "status", status, 32'h0);
    chk("R1", "estatus", estatus, 32'h0);
    chk("R1", "exc", exc, 32'h0);
    chk("R1", "tlbmisc", tlbmisc, 32'h0);
    chk("R1", "ea", ea, 32'h0);
    chk("R1", "ba", ba, 32'h0);
    rst_n = 1'b1;

    // R14 software write path
    preset(4'h3, 2'b10);
    @(negedge clk);
    chk("R14", "sw estatus", estatus, PE);
    chk("R14", "sw bstatus", bstatus, PB);
    chk("R14", "sw exc", exc, PX);
    chk("R14", "sw badaddr", badaddr, PBAD);
    chk("R14", "sw ea", ea, PEA);
    chk("R14", "sw ba", ba, PBA);
    chk("R14", "sw tlbmisc", tlbmisc, 32'h2);
    chk("R14", "sw status", status, 32'h3);

    // table walk
    for (int i = 0; i < NV; i++) begin
      vec_t v;
      logic [31:0] p;
      string t;
      v = TBL[i];
      p = 32'h0000_1000 + 32'(i * 16);
      t = tag_of(v.code, v.st0);
      preset(v.st0, v.tlb_pre);
      strobe(v.code, p, 32'h0);
      @(negedge clk);
      chk("R2", "redir valid", {31'h0, redir_valid}, (v.vsel == 2'd2) ? 32'h0 : 32'h1);
      if (v.vsel != 2'd2)
        chk(t, "redir pc", redir_pc, (v.vsel == 2'd1) ? VFAST : VGEN);
      chk("R3", "status", status, {28'h0, v.exp_st});
      chk("R4", "exc", exc, (v.vsel == 2'd2) ? PX : put5(PX, v.exp_code));
      chk(t, "estatus", estatus, v.sv_e ? {28'h0, v.st0} : PE);
      chk(t, "ea", ea, v.sv_e ? p + 32'd4 : PEA);
      chk(t, "bstatus", bstatus, v.sv_b ? {28'h0, v.st0} : PB);
      chk(t, "ba", ba, v.sv_b ? p + 32'd4 : PBA);
      chk(t, "tlbmisc", tlbmisc, {30'h0, v.tlb_exp});
      @(negedge clk);
      chk("R2", "redir one cycle", {31'h0, redir_valid}, 32'h0);
    end

    // R11 misaligned
    preset(4'h3, 2'b00);
    strobe(5'd6, 32'h0000_3000, 32'hCAFE_0003);
    @(negedge clk);
    chk("R11", "badaddr", badaddr, 32'hCAFE_0003);
    chk("R11", "exc", exc, 32'h0000_0018);
    chk("R11", "estatus", estatus, 32'h3);
    chk("R11", "ea", ea, 32'h0000_3004);
    chk("R11", "status", status, 32'h4);
    chk("R11", "redir pc", redir_pc, VGEN);

    // R13 back-to-back trap then illegal
    preset(4'h3, 2'b00);
    @(negedge clk);
    take = 1'b1; cause = 5'd3; pc = 32'h0000_4000;
    @(negedge clk);
    cause = 5'd5; pc = 32'h0000_4100;
    @(negedge clk);
    take = 1'b0;
    chk("R13", "first redir", {31'h0, redir_valid}, 32'h1);
    chk("R13", "first code", exc, put5(PX, 5'd3));
    @(negedge clk);
    chk("R13", "deferred gap", {31'h0, redir_valid}, 32'h0);
    @(negedge clk);
    chk("R13", "second redir", {31'h0, redir_valid}, 32'h1);
    chk("R13", "second code", exc, put5(PX, 5'd5));
    chk("R13", "ea kept", ea, 32'h0000_4004);
    chk("R13", "estatus kept", estatus, 32'h3);

    // R13 two interrupts, second masked by first
    preset(4'h1, 2'b00);
    @(negedge clk);
    take = 1'b1; cause = 5'd2; pc = 32'h0000_5000;
    @(negedge clk);
    pc = 32'h0000_5100;
    @(negedge clk);
    take = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk("R13", "masked irq redir", {31'h0, redir_valid}, 32'h0);
    chk("R5", "status after irq", status, 32'h8);
    chk("R5", "ea first irq", ea, 32'h0000_5004);

    // R14 software write loses to entry
    preset(4'h3, 2'b00);
    @(negedge clk);
    take = 1'b1; cause = 5'd3; pc = 32'h0000_6000;
    @(negedge clk);
    take = 1'b0;
    sw_we = 1'b1; sw_sel = 3'd1; sw_wdata = 32'hDEAD_BEEF;
    @(negedge clk);
    sw_we = 1'b0;
    chk("R14", "collision estatus", estatus, 32'h3);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule